// File: doc/BRIEF.md
# PLL Lock Detector with Selectable Lock Criteria

This block decides whether a phase-locked loop has settled. The reference clock and the loop's feedback clock both arrive as plain level signals. The block samples them on the fast system clock, synchronises them and turns each rising edge into a one-tick event. For every reference cycle it measures the distance in sample ticks between the reference edge and the feedback edge nearest to it, in either order. It then judges the cycle as inside or outside a tolerance window.

A run counter tallies consecutive cycles that land inside the window. Lock is declared once the run reaches the required length. A 2-bit sensitivity code picks the run length and the window width together, which gives four preset lock criteria. The PLL supplies an enable. While the PLL is disabled the detector is held idle, and this is the only time the sensitivity code may be rewritten. The current code is shown on an output.

The phase judge is a four-state machine:
- OFF: disabled. It goes to HUNT when enabled.
- HUNT: waiting for an edge. Simultaneous edges are judged good at once and the machine stays in HUNT. A lone reference edge goes to REF_LEADS. A lone feedback edge goes to FB_LEADS.
- REF_LEADS and FB_LEADS: counting ticks until the other edge arrives. The arrival is judged and the machine returns to HUNT. If the count reaches the window width first, the cycle is judged bad and the machine returns to HUNT. A repeat of the leading edge is judged bad and restarts the count.
- Any state goes to OFF when the enable drops.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lock` and `lock_lost` are 0 and `sens_q` is 00.
- R2: Bit 0 of the sensitivity code selects the required run: 0 means 8 cycles and 1 means 16 cycles. Bit 1 selects the window: 0 means 1 sample tick and 1 means 20 sample ticks. The four criteria are therefore 00 = 8 cycles within 1 tick, 01 = 16 cycles within 1 tick, 10 = 8 cycles within 20 ticks, and 11 = 16 cycles within 20 ticks.
- R3: The phase error is the tick distance between a reference rising edge and the matching feedback rising edge. Either edge may come first. A cycle is good when this distance is no larger than the window.
- R4: `lock` rises on the good cycle that brings the run to the required count. It stays high while the following cycles remain good.
- R5: A bad cycle clears the run and drops `lock`.
- R6: `lock_lost` pulses high for exactly one cycle each time `lock` falls from 1 to 0, and at no other time.
- R7: While `pll_en` is 0, the run is cleared and `lock` is held at 0.
- R8: A pulse on `sens_wr` loads `sens_code` into `sens_q` only while `pll_en` is 0. A write made while the PLL is enabled is ignored and leaves `sens_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| pll_en | input | 1 | PLL enable; 0 holds the detector idle |
| ref_clk | input | 1 | Reference clock level, sampled |
| fb_clk | input | 1 | Feedback clock level, sampled |
| sens_wr | input | 1 | Write strobe for the sensitivity code |
| sens_code | input | 2 | New sensitivity code |
| sens_q | output | 2 | Sensitivity code in force |
| lock | output | 1 | Lock flag |
| lock_lost | output | 1 | One-cycle pulse when lock is lost |

## Verification
The in-RTL assertions check several properties on every cycle:
- the phase judge never reports good and bad together;
- lock rises only after a good verdict and is low after a bad verdict or a disabled cycle;
- each loss pulse matches a real fall of lock;
- the run never passes the required count;
- the code never changes while the PLL is enabled.

Only the bench scenarios can show the rest of the behaviour. These include the exact cycle on which lock appears for each of the four codes, window edges one tick inside and one tick outside in both edge orders, the loss pulse counts, and an enabled-time write that is truly dropped.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
    typedef enum logic [1:0] {
        PH_OFF,
        PH_HUNT,
        PH_REF_LEADS,
        PH_FB_LEADS
    } phase_state_e;
endpackage

// File: rtl/lock_edge_sync.sv
module lock_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lock_phase_fsm.sv
module lock_phase_fsm
    import pll_lock_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [CNT_W-1:0] win,
    output logic             good,
    output logic             bad
);
    phase_state_e     state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = '0;
        unique case (state)
            PH_OFF:  nxt = PH_HUNT;
            PH_HUNT: begin
                if (ref_rise && !fb_rise)      nxt = PH_REF_LEADS;
                else if (fb_rise && !ref_rise) nxt = PH_FB_LEADS;
            end
            PH_REF_LEADS: begin
                if (fb_rise || cnt >= win) nxt = PH_HUNT;
                else if (!ref_rise)        cnt_nxt = cnt + 1'b1;
            end
            PH_FB_LEADS: begin
                if (ref_rise || cnt >= win) nxt = PH_HUNT;
                else if (!fb_rise)          cnt_nxt = cnt + 1'b1;
            end
        endcase
        if (!en) begin
            nxt     = PH_OFF;
            cnt_nxt = '0;
        end
    end

    // verdict outputs
    always_comb begin
        good = 1'b0;
        bad  = 1'b0;
        if (en) begin
            unique case (state)
                PH_OFF:  ;
                PH_HUNT: good = ref_rise && fb_rise;
                PH_REF_LEADS: begin
                    if (fb_rise)         begin good = (cnt < win); bad = (cnt >= win); end
                    else if (cnt >= win) bad = 1'b1;
                    else if (ref_rise)   bad = 1'b1;
                end
                PH_FB_LEADS: begin
                    if (ref_rise)        begin good = (cnt < win); bad = (cnt >= win); end
                    else if (cnt >= win) bad = 1'b1;
                    else if (fb_rise)    bad = 1'b1;
                end
            endcase
        end
    end

    // R3: a cycle cannot be both inside and outside the window
    assert_single_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(good && bad));
    // R3: the lead counter never runs past the window
    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= win);
endmodule

// File: rtl/lock_run_track.sv
module lock_run_track #(
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             good,
    input  logic             bad,
    input  logic [RUN_W-1:0] target,
    output logic             lock,
    output logic             lock_lost
);
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_inc;

    assign run_inc = {1'b0, run} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run       <= '0;
            lock      <= 1'b0;
            lock_lost <= 1'b0;
        end else if (!en || bad) begin
            run       <= '0;
            lock      <= 1'b0;
            lock_lost <= lock;
        end else begin
            lock_lost <= 1'b0;
            if (good) begin
                if (run < target) run <= run_inc[RUN_W-1:0];
                lock <= (run_inc >= {1'b0, target});
            end
        end
    end

    assert_lost_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |-> (!lock && $past(lock)));
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> !lock);
    assert_drop_on_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bad) |-> !lock);
    assert_rise_needs_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(good));
    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= target);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int RUN_SHORT  = 8,
    parameter int RUN_LONG   = 16,
    parameter int WIN_NARROW = 1,
    parameter int WIN_WIDE   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_en,
    input  logic       ref_clk,
    input  logic       fb_clk,
    input  logic       sens_wr,
    input  logic [1:0] sens_code,
    output logic [1:0] sens_q,
    output logic       lock,
    output logic       lock_lost
);
    localparam int RUN_W = $clog2(RUN_LONG + 1);
    localparam int CNT_W = $clog2(WIN_WIDE + 1);

    logic             ref_rise, fb_rise, good, bad;
    logic [RUN_W-1:0] target;
    logic [CNT_W-1:0] win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sens_q <= 2'b00;
        else if (sens_wr && !pll_en) sens_q <= sens_code;
    end

    assign target = sens_q[0] ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
    assign win    = sens_q[1] ? CNT_W'(WIN_WIDE) : CNT_W'(WIN_NARROW);

    lock_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .din(ref_clk), .rise(ref_rise));
    lock_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .din(fb_clk), .rise(fb_rise));

    lock_phase_fsm #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(pll_en), .ref_rise(ref_rise),
        .fb_rise(fb_rise), .win(win), .good(good), .bad(bad));

    lock_run_track #(.RUN_W(RUN_W)) u_run (
        .clk(clk), .rst_n(rst_n), .en(pll_en), .good(good), .bad(bad),
        .target(target), .lock(lock), .lock_lost(lock_lost));

    assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pll_en) |-> $stable(sens_q));
endmodule

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
    localparam int P   = 64;
    localparam int OFS = 30;

    logic       clk = 0, rst_n = 0, pll_en = 0, ref_clk = 0, fb_clk = 0, sens_wr = 0;
    logic [1:0] sens_code = 0;
    logic [1:0] sens_q;
    logic       lock, lock_lost;

    int checks = 0, errors = 0, lost_seen = 0, lost_exp = 0;
    int mdl_run = 0;
    logic mdl_lock = 0;
    logic [1:0] mdl_code = 0;
    bit done = 0;

    typedef struct { logic lk; int lost; logic [1:0] code; string req; } exp_t;
    exp_t q[$];
    event chk_ev;

    pll_lock_detect uut (.clk(clk), .rst_n(rst_n), .pll_en(pll_en), .ref_clk(ref_clk),
        .fb_clk(fb_clk), .sens_wr(sens_wr), .sens_code(sens_code), .sens_q(sens_q),
        .lock(lock), .lock_lost(lock_lost));

    always #10 clk = ~clk;

    // loss pulse counter, sampled 1 ns after each edge
    initial forever begin
        @(posedge clk); #1;
        if (rst_n && lock_lost) lost_seen++;
    end

    // monitor: pop and compare
    initial forever begin
        exp_t e;
        @(chk_ev);
        while (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (lock !== e.lk || lost_seen != e.lost || sens_q !== e.code) begin
                errors++;
                $display("FAIL %s: lock=%0b lost=%0d code=%0b expected lock=%0b lost=%0d code=%0b",
                         e.req, lock, lost_seen, sens_q, e.lk, e.lost, e.code);
            end
        end
    end

    task automatic push(string req);
        exp_t e;
        e.lk = mdl_lock; e.lost = lost_exp; e.code = mdl_code; e.req = req;
        q.push_back(e);
        -> chk_ev;
    endtask

    // one reference period with feedback offset d ticks
    task automatic cycle(int d, string req);
        int win, ad, need;
        for (int t = 0; t < P; t++) begin
            @(negedge clk);
            ref_clk = (t >= OFS && t < OFS + 4);
            fb_clk  = (t >= OFS + d && t < OFS + d + 4);
        end
        win  = mdl_code[1] ? 20 : 1;
        need = mdl_code[0] ? 16 : 8;
        ad   = (d < 0) ? -d : d;
        if (ad <= win) begin
            if (mdl_run < need) mdl_run++;
            mdl_lock = (mdl_run >= need);
        end else begin
            if (mdl_lock) lost_exp++;
            mdl_run = 0; mdl_lock = 0;
        end
        push(req);
    endtask

    task automatic cycles(int n, int d, string req);
        for (int i = 0; i < n; i++) cycle(d, req);
    endtask

    task automatic set_en(logic v, string req);
        @(negedge clk); pll_en = v;
        if (!v) begin
            if (mdl_lock) lost_exp++;
            mdl_lock = 0; mdl_run = 0;
        end
        repeat (6) @(negedge clk);
        push(req);
    endtask

    task automatic write_code(logic [1:0] c, string req);
        @(negedge clk); sens_wr = 1; sens_code = c;
        @(negedge clk); sens_wr = 0;
        if (!pll_en) mdl_code = c;
        push(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        push("R1 reset state");

        // code 00: 8 cycles within 1 tick
        set_en(1, "R7 enable");
        cycles(8, 1, "R4 R2 code00 lag 1 lock at 8th");
        cycles(2, 0, "R4 lock holds");
        cycle(2, "R5 R3 lag 2 outside narrow");
        cycles(8, -1, "R3 feedback leads by 1");
        // write while enabled is ignored
        write_code(2'b11, "R8 enabled write ignored");
        cycle(2, "R5 R6 drop after ignored write");
        cycles(8, 1, "R8 R2 still 8-cycle narrow criteria");
        // disable drops lock
        set_en(0, "R7 R6 disable drops lock");
        write_code(2'b01, "R8 disabled write taken");
        set_en(1, "R7 re-enable");
        cycles(16, 0, "R2 code01 needs 16");
        cycle(1, "R3 R2 code01 lag 1 in window");
        set_en(0, "R7 disable");
        write_code(2'b10, "R8 code10");
        set_en(1, "R7 enable code10");
        cycles(8, 20, "R2 R3 code10 lag 20 inside");
        cycle(21, "R5 R3 code10 lag 21 outside");
        cycles(3, -20, "R3 code10 lead 20");
        set_en(0, "R7 disable");
        write_code(2'b11, "R8 code11");
        set_en(1, "R7 enable code11");
        cycles(16, -20, "R2 code11 16 cycles wide");
        cycle(-21, "R5 R6 code11 lead 21 outside");
        repeat (4) @(negedge clk);
        push("R6 final loss count");
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule